// File: doc/BRIEF.md
# Two-Channel Rotation Counter with Quadrature Decode and Flutter Watch

This block counts pulses from two already-debounced channel levels. It works in one of three counting styles. In single style, one channel feeds one counter. In dual style, each channel feeds its own counter. In quadrature style, the pair of levels is decoded as a two-bit rotary code, and steps in each direction go to separate counters. Both counters only count upward and wrap around. A configuration write clears them, and no other path can change them.

The block watches for one channel toggling while the other stays still. Four small edge counters do this, one for each edge kind. When any of them saturates, flutter is active. In quadrature style, active flutter can either freeze both counters or switch counting to dual style until the flutter ends. Sticky start and end flags mark the flutter boundaries, and a write-one-to-clear input releases them. A two-entry direction history records the most recent decoded directions.

All inputs are acted on only in clock cycles where the sample strobe is high. Each registered output changes at the clock edge that takes the strobe, and is visible from the next cycle onward.

Top module: `qc_rot_counter`

## Requirements
- R1: In quadrature mode (mode 2'b11), with the state written as {ch1,ch0}, a clockwise step (00→10→11→01→00) increments counter 0 by one. A counter-clockwise step (the reverse order) increments counter 1 by one.
- R2: In quadrature mode, a sample in which both channels change sets a sticky error flag and counts nothing. In single or dual mode the flag never sets. A config write clears it.
- R3: In single mode (2'b01), each rising edge of ch0 increments counter 0. Counter 1 and channel 1 have no effect.
- R4: In dual mode (2'b10), each rising edge of ch0 increments counter 0 and each rising edge of ch1 increments counter 1. Both can happen in the same sample.
- R5: Counters wrap from all-ones to zero.
- R6: A config write clears both counters, the quadrature state (to 2'b00), the error flag, the direction history, the flutter counters and both sticky flutter flags.
- R7: Level changes have no effect in cycles without the sample strobe.
- R8: In dual or quadrature mode there are four flutter counters. Flag bit 0 is ch0 rising, bit 1 is ch0 falling, bit 2 is ch1 rising and bit 3 is ch1 falling. Each counter is cleared by its own edge and incremented by any edge on the other channel. Its flag bit is high while it holds 4, and flutter is active while any bit is high.
- R9: In quadrature mode, with the hold option set and the dual fallback option clear, no counter changes on a sample taken while flutter was active before that sample.
- R10: In quadrature mode, with the fallback option set, samples taken while flutter is active count in dual style, whatever the hold option says. Quadrature counting resumes once flutter has ended.
- R11: The start flag sets when flutter becomes active and the end flag sets when it becomes inactive. Each stays set until its bit of the clear input (bit 0 start, bit 1 end) is pulsed.
- R12: Each valid quadrature step shifts its direction (1 = clockwise) into history bit 0, and the old bit 0 moves to bit 1.
- R13: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_i | input | 1 | Sample strobe |
| ch0_i | input | 1 | Channel 0 level |
| ch1_i | input | 1 | Channel 1 level |
| mode_i | input | 2 | 00 off, 01 single, 10 dual, 11 quadrature |
| cfg_wr_i | input | 1 | Config write strobe, clears state |
| flut_hold_i | input | 1 | Freeze counters during flutter (quadrature) |
| flut_dual_i | input | 1 | Dual-style counting during flutter (quadrature) |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 start, bit 1 end |
| cnt0_o | output | CNT_W | Counter 0 |
| cnt1_o | output | CNT_W | Counter 1 |
| qstate_o | output | 2 | Last sampled {ch1,ch0} |
| qerr_o | output | 1 | Sticky quadrature error |
| dir_hist_o | output | 2 | Last two directions, bit 0 newest |
| flut_act_o | output | 1 | Flutter active |
| flut_edge_o | output | 4 | Per-edge flutter flags |
| flut_start_o | output | 1 | Sticky flutter-start flag |
| flut_end_o | output | 1 | Sticky flutter-end flag |

## Verification
The bench builds the block with a counter width of 4 bits instead of 24. This brings the wrap from all-ones to zero within sixteen edges. The flutter limit stays at its default of 4, so the saturation point, the hold and fallback behaviour, and the order in which flutter ends can each be reached in a handful of samples, including the cycle where the decision switches.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_DUAL   = 2'b10,
    MODE_QUAD   = 2'b11
  } qc_mode_e;

  typedef struct packed {
    logic f1;  // ch1 falling
    logic r1;  // ch1 rising
    logic f0;  // ch0 falling
    logic r0;  // ch0 rising
  } qc_edges_t;

  // Clockwise successor of a {ch1,ch0} state
  function automatic logic [1:0] cw_next(input logic [1:0] s);
    case (s)
      2'b00:   cw_next = 2'b10;
      2'b10:   cw_next = 2'b11;
      2'b11:   cw_next = 2'b01;
      default: cw_next = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/qc_counter.sv
module qc_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R5
  AST_CNT_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_i && !clr_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/qc_quad_track.sv
module qc_quad_track
  import qc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic [1:0] lvl_i,      // {ch1,ch0}
  input  logic       cfg_wr_i,
  input  logic       quad_en_i,
  output qc_edges_t  edges_o,
  output logic       cw_o,
  output logic       ccw_o,
  output logic [1:0] state_o,
  output logic       qerr_o,
  output logic [1:0] dir_hist_o
);
  logic [1:0] prev_q, prev_d;
  logic       qerr_q, qerr_d;
  logic [1:0] dh_q, dh_d;
  logic [1:0] chg;
  logic       cw_s, ccw_s, bad_s;

  assign chg = lvl_i ^ prev_q;

  always_comb begin
    edges_o.r0 = smp_i &  lvl_i[0] & ~prev_q[0];
    edges_o.f0 = smp_i & ~lvl_i[0] &  prev_q[0];
    edges_o.r1 = smp_i &  lvl_i[1] & ~prev_q[1];
    edges_o.f1 = smp_i & ~lvl_i[1] &  prev_q[1];
  end

  assign cw_s  = smp_i & (lvl_i == cw_next(prev_q));
  assign ccw_s = smp_i & (prev_q == cw_next(lvl_i));
  assign bad_s = smp_i & (chg == 2'b11);

  always_comb begin
    prev_d = prev_q;
    qerr_d = qerr_q;
    dh_d   = dh_q;
    if (cfg_wr_i) begin
      prev_d = 2'b00;
      qerr_d = 1'b0;
      dh_d   = 2'b00;
    end else if (smp_i) begin
      prev_d = lvl_i;
      if (quad_en_i && bad_s)            qerr_d = 1'b1;
      if (quad_en_i && (cw_s || ccw_s))  dh_d   = {dh_q[0], cw_s};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 2'b00;
      qerr_q <= 1'b0;
      dh_q   <= 2'b00;
    end else if (cfg_wr_i || smp_i) begin
      prev_q <= prev_d;
      qerr_q <= qerr_d;
      dh_q   <= dh_d;
    end
  end

  assign cw_o       = cw_s;
  assign ccw_o      = ccw_s;
  assign state_o    = prev_q;
  assign qerr_o     = qerr_q;
  assign dir_hist_o = dh_q;

  AST_CFG_CLEARS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> (prev_q == 2'b00 && !qerr_q && dh_q == 2'b00)); // R6
  AST_QERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qerr_q) |-> ($past(smp_i) && $past(quad_en_i))); // R2
endmodule

// File: rtl/qc_flutter.sv
module qc_flutter
  import qc_pkg::*;
#(
  parameter int LIMIT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  qc_edges_t  edges_i,
  input  logic       en_i,
  input  logic       cfg_wr_i,
  input  logic [1:0] clr_i,
  output logic [3:0] flag_o,
  output logic       act_o,
  output logic       start_o,
  output logic       end_o
);
  localparam int FW = $clog2(LIMIT + 1);

  logic [3:0] own, other;
  logic [3:0] flag_d;
  logic       act_d, act_q;
  logic       start_q, start_d, end_q, end_d;

  assign own   = {edges_i.f1, edges_i.r1, edges_i.f0, edges_i.r0};
  assign other = {{2{edges_i.r0 | edges_i.f0}}, {2{edges_i.r1 | edges_i.f1}}};

  for (genvar i = 0; i < 4; i++) begin : g_fc
    logic [FW-1:0] fc_q, fc_d;
    logic          fc_en;

    always_comb begin
      fc_d = fc_q;
      if (cfg_wr_i || !en_i)                     fc_d = '0;
      else if (own[i])                           fc_d = '0;
      else if (other[i] && fc_q != FW'(LIMIT))   fc_d = fc_q + 1'b1;
    end

    assign fc_en     = cfg_wr_i | ~en_i | own[i] | other[i];
    assign flag_o[i] = (fc_q == FW'(LIMIT));
    assign flag_d[i] = (fc_d == FW'(LIMIT));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    fc_q <= '0;
      else if (fc_en) fc_q <= fc_d;
    end

    AST_FC_OWN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own[i] |=> (fc_q == '0)); // R8
  end

  assign act_q = |flag_o;
  assign act_d = |flag_d;

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    if (cfg_wr_i) begin
      start_d = 1'b0;
      end_d   = 1'b0;
    end else begin
      if (act_d && !act_q)      start_d = 1'b1;
      else if (clr_i[0])        start_d = 1'b0;
      if (!act_d && act_q)      end_d   = 1'b1;
      else if (clr_i[1])        end_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
    end
  end

  assign act_o   = act_q;
  assign start_o = start_q;
  assign end_o   = end_q;

  AST_START_WITH_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_q) |-> act_q); // R11
endmodule

// File: rtl/qc_rot_counter.sv
module qc_rot_counter
  import qc_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int FLUT_LIMIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             ch0_i,
  input  logic             ch1_i,
  input  logic [1:0]       mode_i,
  input  logic             cfg_wr_i,
  input  logic             flut_hold_i,
  input  logic             flut_dual_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] cnt0_o,
  output logic [CNT_W-1:0] cnt1_o,
  output logic [1:0]       qstate_o,
  output logic             qerr_o,
  output logic [1:0]       dir_hist_o,
  output logic             flut_act_o,
  output logic [3:0]       flut_edge_o,
  output logic             flut_start_o,
  output logic             flut_end_o
);
  qc_mode_e   mode;
  qc_edges_t  edges;
  logic       cw, ccw;
  logic       quad_en, flut_en, act;
  logic [1:0] inc;

  assign mode    = qc_mode_e'(mode_i);
  assign quad_en = (mode == MODE_QUAD);
  assign flut_en = (mode == MODE_QUAD) || (mode == MODE_DUAL);

  qc_quad_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_i      (smp_i),
    .lvl_i      ({ch1_i, ch0_i}),
    .cfg_wr_i   (cfg_wr_i),
    .quad_en_i  (quad_en),
    .edges_o    (edges),
    .cw_o       (cw),
    .ccw_o      (ccw),
    .state_o    (qstate_o),
    .qerr_o     (qerr_o),
    .dir_hist_o (dir_hist_o)
  );

  qc_flutter #(.LIMIT(FLUT_LIMIT)) u_flutter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edges_i  (edges),
    .en_i     (flut_en),
    .cfg_wr_i (cfg_wr_i),
    .clr_i    (flag_clr_i),
    .flag_o   (flut_edge_o),
    .act_o    (act),
    .start_o  (flut_start_o),
    .end_o    (flut_end_o)
  );

  // Count steering: flutter state is the one held before this sample
  always_comb begin
    inc = 2'b00;
    case (mode)
      MODE_SINGLE: inc = {1'b0, edges.r0};
      MODE_DUAL:   inc = {edges.r1, edges.r0};
      MODE_QUAD: begin
        if (act && flut_dual_i)      inc = {edges.r1, edges.r0};
        else if (act && flut_hold_i) inc = 2'b00;
        else                         inc = {ccw, cw};
      end
      default:     inc = 2'b00;
    endcase
  end

  logic [1:0][CNT_W-1:0] cnt;

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    qc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp_i),
      .clr_i  (cfg_wr_i),
      .inc_i  (inc[k]),
      .cnt_o  (cnt[k])
    );
  end

  assign cnt0_o     = cnt[0];
  assign cnt1_o     = cnt[1];
  assign flut_act_o = act;

  AST_HOLD_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_en && act && flut_hold_i && !flut_dual_i && !cfg_wr_i)
      |=> ($stable(cnt0_o) && $stable(cnt1_o))); // R9
  AST_SINGLE_CNT1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SINGLE && !cfg_wr_i) |=> $stable(cnt1_o)); // R3
endmodule

// File: tb/tb_qc_rot_counter.sv
module tb_qc_rot_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp = 1'b0, ch0 = 1'b0, ch1 = 1'b0, cfg_wr = 1'b0;
  logic         hold = 1'b0, fdual = 1'b0;
  logic [1:0]   mode = 2'b00, fclr = 2'b00;
  logic [W-1:0] c0, c1;
  logic [1:0]   qst, dh;
  logic         qerr, fact, fstart, fend;
  logic [3:0]   fedge;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  qc_rot_counter #(.CNT_W(W), .FLUT_LIMIT(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .ch0_i(ch0), .ch1_i(ch1),
    .mode_i(mode), .cfg_wr_i(cfg_wr), .flut_hold_i(hold), .flut_dual_i(fdual),
    .flag_clr_i(fclr), .cnt0_o(c0), .cnt1_o(c1), .qstate_o(qst), .qerr_o(qerr),
    .dir_hist_o(dh), .flut_act_o(fact), .flut_edge_o(fedge),
    .flut_start_o(fstart), .flut_end_o(fend)
  );

  // {lvl[1:0], c0[3:0], c1[3:0], err, dh[1:0]} in quadrature mode
  localparam logic [12:0] VEC [0:8] = '{
    13'b10_0001_0000_0_01,
    13'b11_0010_0000_0_11,
    13'b01_0011_0000_0_11,
    13'b00_0100_0000_0_11,
    13'b01_0100_0001_0_10,
    13'b11_0100_0010_0_00,
    13'b01_0101_0010_0_01,
    13'b00_0110_0010_0_11,
    13'b11_0110_0010_1_11
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] v);
    @(negedge clk);
    {ch1, ch0} = v;
    smp = 1'b1;
    @(negedge clk);
    smp = 1'b0;
  endtask

  task automatic cfg();
    @(negedge clk);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cnts(input string tag, input int e0, input int e1);
    chk(c0 == W'(e0), {tag, " cnt0"}, c0, e0);
    chk(c1 == W'(e1), {tag, " cnt1"}, c1, e1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    // R13 reset state
    repeat (3) @(negedge clk);
    chk({c0, c1, qst, qerr, dh, fact, fedge, fstart, fend} == '0, "R13 reset outputs", 1, 0);
    rst_n = 1'b1;

    // R1 R2 R12 table in quadrature mode
    mode = 2'b11;
    cfg();
    for (int i = 0; i < 9; i++) begin
      step(VEC[i][12:11]);
      cnts("R1 vec", int'(VEC[i][10:7]), int'(VEC[i][6:3]));
      chk(qerr == VEC[i][2], "R2 vec qerr", qerr, VEC[i][2]);
      chk(dh == VEC[i][1:0], "R12 vec dir history", dh, VEC[i][1:0]);
      chk(qst == VEC[i][12:11], "R1 vec state", qst, VEC[i][12:11]);
    end

    // R6 config write clears all
    cfg();
    cnts("R6 cfg clear", 0, 0);
    chk(qerr == 1'b0 && qst == 2'b00 && dh == 2'b00, "R6 cfg state", {qerr, qst, dh}, 0);

    // R3 single mode
    mode = 2'b01;
    step(2'b01); step(2'b00); step(2'b01);
    step(2'b11);
    cnts("R3 single", 2, 0);
    step(2'b00);
    chk(qerr == 1'b0, "R2 no error outside quad", qerr, 0);

    // R7 no strobe, then R4 dual
    mode = 2'b10;
    cfg();
    @(negedge clk);
    {ch1, ch0} = 2'b11;
    repeat (3) @(negedge clk);
    cnts("R7 no strobe", 0, 0);
    chk(qst == 2'b00, "R7 state held", qst, 0);
    step(2'b11);
    cnts("R4 dual both", 1, 1);
    step(2'b10); step(2'b00); step(2'b01);
    cnts("R4 dual ch0", 2, 1);

    // R5 wrap at 4 bits
    cfg();
    for (int i = 0; i < 15; i++) begin
      step(2'b01); step(2'b00);
    end
    cnts("R5 before wrap", 15, 0);
    step(2'b01);
    cnts("R5 wrap", 0, 0);

    // R8 R9 R11 flutter with hold
    mode = 2'b11; hold = 1'b1; fdual = 1'b0;
    cfg();
    step(2'b10); step(2'b00); step(2'b10); step(2'b00);
    cnts("R9 before flutter", 2, 2);
    chk(fact == 1'b1, "R8 flutter active", fact, 1);
    chk(fedge == 4'b0011, "R8 edge flags", fedge, 3);
    chk(fstart == 1'b1 && fend == 1'b0, "R11 start flag", {fstart, fend}, 2);
    step(2'b10); step(2'b00);
    cnts("R9 held", 2, 2);
    step(2'b01);
    chk(fedge == 4'b0010 && fact, "R8 partial clear", fedge, 2);
    step(2'b00);
    chk(fact == 1'b0, "R8 flutter ended", fact, 0);
    chk(fend == 1'b1, "R11 end flag", fend, 1);
    cnts("R9 held at end", 2, 2);
    step(2'b01);
    cnts("R9 resumed", 2, 3);
    @(negedge clk); fclr = 2'b01;
    @(negedge clk); fclr = 2'b00;
    chk(fstart == 1'b0 && fend == 1'b1, "R11 clear start only", {fstart, fend}, 1);

    // R10 fallback to dual style, hold ignored
    fdual = 1'b1;
    cfg();
    chk(fstart == 1'b0 && fend == 1'b0, "R6 flags cleared", {fstart, fend}, 0);
    step(2'b10); step(2'b00); step(2'b10); step(2'b00);
    cnts("R10 before flutter", 2, 2);
    step(2'b10);
    cnts("R10 dual ch1 rise", 2, 3);
    step(2'b00); step(2'b01);
    cnts("R10 dual ch0 rise", 3, 3);
    step(2'b00);
    chk(fact == 1'b0, "R10 flutter ended", fact, 0);
    step(2'b01);
    cnts("R10 quad resumed", 3, 4);

    done = 1'b1;
    summary();
  end
endmodule